// File: doc/BRIEF.md
# Oversampling Serial Receiver with Error Flags

This block turns an asynchronous, idle-high serial line into parallel characters. It runs on the system clock and advances only on a clock enable that pulses at sixteen times the bit rate. A falling edge on the line arms a bit-cell counter. The start bit is accepted only if the line is still low at the middle of the cell. After that, every data bit, the optional parity bit and the first stop bit are sampled at the middle of their own cells.

When the first stop bit is sampled, the character is copied into a holding register. The block then reports four flags: a new character is available, an overrun occurred, the parity did not match, or the framing was bad. The line is passed through a two-flop synchronizer before any use. A one-cycle clear pulse from the consumer acknowledges a character. Character length, parity enable and parity sense come in as static format inputs. They must not change while a frame is being received.

Top module: `serial_rx_deser`

## Requirements
- R1: While `rst_n` is low, `hold_data`, `data_avail`, `overrun_err`, `parity_err` and `framing_err` are all 0.
- R2: A low level on the line begins a start bit. It is kept only if the line is still low on the 8th enable pulse after it was seen. A low pulse shorter than that is dropped: no output changes and no character is loaded.
- R3: Data bits arrive least significant bit first. Each bit is sampled once per 16 enable pulses, at the centre of its cell.
- R4: `len_sel` sets the character length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. The received bits sit right-aligned in `hold_data`, and every bit above the character length reads 0.
- R5: When `par_off` is 0, one parity bit follows the data. With `par_even`=1 the data and parity bits together must hold an even number of ones; with `par_even`=0 an odd number. A mismatch sets `parity_err`. When `par_off` is 1, no parity bit is expected and `parity_err` is 0 on every load.
- R6: `framing_err` is set on a load if the first stop bit is low, and cleared on a load if it is high.
- R7: `overrun_err` is set on a load if `data_avail` was still 1 when the load happened, and cleared on a load if `data_avail` was 0.
- R8: A load sets `data_avail`. A `da_clr` pulse in a cycle with no load clears it.
- R9: After a character with a low stop bit, the line must go high before a new start bit is accepted. A line held low therefore yields no further characters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, clears holding register and flags |
| tick16 | input | 1 | Enable pulse at 16 times the bit rate |
| rxd | input | 1 | Asynchronous serial input, idle high |
| len_sel | input | 2 | Character length: 00=5, 01=6, 10=7, 11=8 bits |
| par_off | input | 1 | 1: no parity bit |
| par_even | input | 1 | 1: even parity, 0: odd parity |
| da_clr | input | 1 | One-cycle pulse that clears `data_avail` |
| hold_data | output | 8 | Last received character, zero-filled above its length |
| data_avail | output | 1 | A character is waiting |
| overrun_err | output | 1 | Last load overwrote an unread character |
| parity_err | output | 1 | Parity mismatch on the last character |
| framing_err | output | 1 | Low stop bit on the last character |

## Verification
Characters are sent in every length from five to eight bits, each with a data value whose upper bits are set. This shows whether zero fill and right alignment work for each length. Even and odd parity are sent both with the correct parity bit and with an inverted one, so a swapped sense and a missing check each produce a visible mismatch. Two kinds of line pattern are used. A short low glitch must be rejected, and a low stop bit is followed by a long low hold; together these separate false-start filtering from re-arming after a framing error. Two characters are then sent back to back without a clear, and a third after a clear, which shows that overrun is both set and cleared on a load.

// File: rtl/serial_rx_deser.sv
module serial_rx_deser #(
  parameter int OSR = 16,
  parameter int MID = OSR / 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       rxd,
  input  logic [1:0] len_sel,
  input  logic       par_off,
  input  logic       par_even,
  input  logic       da_clr,
  output logic [7:0] hold_data,
  output logic       data_avail,
  output logic       overrun_err,
  output logic       parity_err,
  output logic       framing_err
);
  localparam int CW = $clog2(OSR);

  typedef enum logic [2:0] {S_WAITH, S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t           state;
  logic [1:0]    sync;
  logic [CW-1:0] cnt;
  logic [2:0]    bidx;
  logic [7:0]    sh;
  logic          pbit;
  logic          rx_s, mid, ld, ones;
  logic [7:0]    aligned;

  assign rx_s    = sync[1];
  assign mid     = tick16 && (cnt == CW'(MID - 1));
  assign ld      = mid && (state == S_STOP);
  assign aligned = sh >> (2'd3 - len_sel);
  assign ones    = (^aligned) ^ pbit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], rxd};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_WAITH;
      cnt   <= '0;
      bidx  <= '0;
      sh    <= '0;
      pbit  <= 1'b0;
    end else if (tick16) begin
      cnt <= (state == S_IDLE || state == S_WAITH) ? '0 : cnt + 1'b1;
      unique case (state)
        S_WAITH: if (rx_s) state <= S_IDLE;
        S_IDLE:  if (!rx_s) state <= S_START;
        S_START: if (mid) begin
          state <= rx_s ? S_IDLE : S_DATA;
          bidx  <= '0;
          sh    <= '0;
          pbit  <= 1'b0;
        end
        S_DATA: if (mid) begin
          sh   <= {rx_s, sh[7:1]};
          bidx <= bidx + 1'b1;
          if (bidx == 3'd4 + {1'b0, len_sel}) state <= par_off ? S_STOP : S_PAR;
        end
        S_PAR: if (mid) begin
          pbit  <= rx_s;
          state <= S_STOP;
        end
        S_STOP: if (mid) state <= rx_s ? S_IDLE : S_WAITH;
        default: state <= S_WAITH;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_data   <= '0;
      data_avail  <= 1'b0;
      overrun_err <= 1'b0;
      parity_err  <= 1'b0;
      framing_err <= 1'b0;
    end else if (ld) begin
      hold_data   <= aligned;
      data_avail  <= 1'b1;
      overrun_err <= data_avail;
      parity_err  <= !par_off && (ones ^ !par_even);
      framing_err <= !rx_s;
    end else if (da_clr) begin
      data_avail  <= 1'b0;
    end
  end

  AST_DA_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (da_clr && !ld) |=> !data_avail); // R8
  AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun_err) |-> $past(data_avail)); // R7
  AST_PAR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && par_off) |=> !parity_err); // R5
  AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> ((hold_data >> (4'd5 + {2'b00, $past(len_sel)})) == 8'd0)); // R4
  AST_HOLD_ONLY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(hold_data) |-> $past(ld)); // R2
  AST_WAIT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAITH && !rx_s) |=> state != S_START); // R9
endmodule

// File: tb/serial_rx_deser_bench.sv
module serial_rx_deser_bench;
  localparam int TDIV = 4;
  localparam int BT   = 16 * TDIV;

  logic       clk = 1'b0, rst_n = 1'b0, tick16 = 1'b0, rxd = 1'b1;
  logic [1:0] len_sel = 2'b11;
  logic       par_off = 1'b1, par_even = 1'b0, da_clr = 1'b0;
  logic [7:0] hold_data;
  logic       data_avail, overrun_err, parity_err, framing_err;

  int checks = 0, errors = 0, events = 0;
  logic exp_da = 1'b0, mon_on = 1'b0;

  typedef struct { logic [7:0] d; logic da, ov, pe, fe; string tag; } exp_t;
  exp_t q[$];

  serial_rx_deser u_serial_rx_deser (.*);

  always #5 clk = ~clk;

  initial forever begin
    repeat (TDIV - 1) @(negedge clk);
    tick16 = 1'b1;
    @(negedge clk);
    tick16 = 1'b0;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  logic [11:0] prev, cur;
  always @(negedge clk) begin
    cur = {hold_data, data_avail, overrun_err, parity_err, framing_err};
    if (mon_on && cur != prev && !(((cur ^ prev) == 12'h008) && !cur[3])) begin
      events++;
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL R2: unexpected load actual=%h expected none", cur);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (cur != {e.d, e.da, e.ov, e.pe, e.fe}) begin
          errors++;
          $display("FAIL %s: actual hold=%h da/ov/pe/fe=%b expected hold=%h da/ov/pe/fe=%b",
                   e.tag, cur[11:4], cur[3:0], e.d, {e.da, e.ov, e.pe, e.fe});
        end
      end
    end
    prev = cur;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bit_out(input logic v);
    rxd = v;
    repeat (BT) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input bit bad_par, input logic stop, input string tag);
    exp_t e;
    int n;
    logic [7:0] mask;
    logic p;
    n    = 5 + int'(len_sel);
    mask = 8'hFF >> (8 - n);
    e.d  = d & mask;
    e.da = 1'b1;
    e.ov = exp_da;
    e.pe = !par_off && bad_par;
    e.fe = !stop;
    e.tag = tag;
    q.push_back(e);
    exp_da = 1'b1;
    p = (par_even ? ^(d & mask) : ~^(d & mask)) ^ bad_par;
    bit_out(1'b0);
    for (int i = 0; i < n; i++) bit_out(d[i]);
    if (!par_off) bit_out(p);
    bit_out(stop);
    rxd = 1'b1;
    repeat (2 * BT) @(negedge clk);
  endtask

  task automatic clear_da();
    @(negedge clk);
    da_clr = 1'b1;
    @(negedge clk);
    da_clr = 1'b0;
    exp_da = 1'b0;
    @(negedge clk);
    check(data_avail == 1'b0, "R8 clear", data_avail, 0);
  endtask

  initial begin
    int ev0;
    repeat (5) @(negedge clk);
    check({hold_data, data_avail, overrun_err, parity_err, framing_err} == 12'h0, "R1 reset",
          {hold_data, data_avail, overrun_err, parity_err, framing_err}, 0);
    rst_n = 1'b1;
    repeat (2 * BT) @(negedge clk);
    prev = {hold_data, data_avail, overrun_err, parity_err, framing_err};
    mon_on = 1'b1;

    len_sel = 2'b11; par_off = 1'b1;
    send(8'hA5, 0, 1'b1, "R3 8N A5"); clear_da();
    send(8'h3C, 0, 1'b1, "R3 8N 3C"); clear_da();
    len_sel = 2'b00;
    send(8'hFF, 0, 1'b1, "R4 5N zero fill"); clear_da();
    len_sel = 2'b01; par_off = 1'b0; par_even = 1'b1;
    send(8'hED, 0, 1'b1, "R4 R5 6E good"); clear_da();
    len_sel = 2'b10; par_even = 1'b0;
    send(8'hD5, 0, 1'b1, "R4 R5 7O good"); clear_da();
    len_sel = 2'b11; par_even = 1'b1;
    send(8'h96, 1, 1'b1, "R5 8E bad parity"); clear_da();
    par_even = 1'b0;
    send(8'h0F, 1, 1'b1, "R5 8O bad parity"); clear_da();
    par_off = 1'b1;

    ev0 = events;
    rxd = 1'b0;
    repeat (3 * TDIV) @(negedge clk);
    rxd = 1'b1;
    repeat (2 * BT) @(negedge clk);
    check(events == ev0, "R2 false start", events - ev0, 0);
    send(8'h42, 0, 1'b1, "R2 frame after glitch"); clear_da();

    exp_da = 1'b0;
    q.push_back('{8'h5A, 1'b1, 1'b0, 1'b0, 1'b1, "R6 framing error"});
    exp_da = 1'b1;
    bit_out(1'b0);
    for (int i = 0; i < 8; i++) bit_out(((8'h5A >> i) & 8'h01) != 0);
    bit_out(1'b0);
    ev0 = events;
    repeat (4 * BT) @(negedge clk);
    check(events == ev0, "R9 no start while low", events - ev0, 0);
    rxd = 1'b1;
    repeat (2 * BT) @(negedge clk);
    clear_da();
    send(8'h81, 0, 1'b1, "R6 R9 good after framing"); clear_da();

    send(8'h11, 0, 1'b1, "R7 first");
    send(8'h22, 0, 1'b1, "R7 overrun set");
    clear_da();
    send(8'h33, 0, 1'b1, "R7 overrun cleared"); clear_da();

    repeat (BT) @(negedge clk);
    check(q.size() == 0, "R3 all loads seen", q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule